// File: doc/BRIEF.md
# Circular-Buffer Receive DMA Address Engine

This block holds the address, length and staging state of one receive DMA channel that carries bytes from a serial port into a ring buffer in memory. Incoming characters land in a four-byte staging queue. Whenever the queue holds data and the remaining length is non-zero, the block requests a memory write. It presents a 24-bit address built from a fixed segment byte and a 16-bit moving pointer. Each accepted write advances the pointer. When the pointer reaches the ring's upper limit, it folds back to a 256-byte-aligned start page.

The block also keeps a working length counter that stops the channel when it is used up. A character idle timer raises a sticky interrupt when no new byte has arrived for a programmed number of prescaled ticks while data is still waiting in the queue. Software sets the channel up through a small select/data write port. Bus arbitration is outside the block.

Top module: `dma_circ_chan`

## Requirements
- R1: `mem_addr` is the segment byte (select 0, `cfg_wdata[7:0]`) in bits 23..16 and the moving pointer in bits 15..0. The segment changes only when select 0 is written, never on pointer fold-back.
- R2: The ring start register (select 1, `cfg_wdata[7:0]`) supplies only pointer bits 15..8, so every fold-back lands at `start*256` plus any overshoot.
- R3: An accepted write advances the pointer by 1 for a byte and by 2 for a word. If the pointer was below the limit (select 2) and the advance reaches or passes it, the new pointer is `start*256 + (old + step - limit)`. Select 3 loads the pointer directly.
- R4: A write is a word (`mem_wide`=1) only when `word_mode` is 1, at least two bytes are queued and the remaining length is at least 2. A word carries the older byte in `mem_data[7:0]`. A byte write carries it in `mem_data[7:0]` with `mem_data[15:8]`=0.
- R5: Select 4 loads the remaining length. Each accepted write subtracts the bytes it moved. `xfer_done` is 1 at zero. While done, `mem_req` is 0, `mem_ack` has no effect and the pointer does not move.
- R6: The queue holds four bytes in arrival order and reports `fifo_level`, `fifo_full` and `fifo_empty`. A byte offered while four are held is discarded.
- R7: A push and a pop in the same cycle leave `fifo_level` unchanged and keep arrival order.
- R8: Every received byte reloads the idle timer from the reload register (select 5) and restarts the prescaler. The timer counts down once per PRESCALE cycles. `tmo_irq` is set on the clock edge R*PRESCALE edges after the last byte if the queue is non-empty then.
- R9: `tmo_irq` stays set until a write to select 6 clears it. It is not set if the queue is empty when the timer expires, and a byte arriving on a tick edge reloads rather than decrements.
- R10: After reset, the queue is empty, the length is zero with `xfer_done`=1, `mem_req`=0, `tmo_irq`=0 and `mem_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select (0..6) |
| cfg_wdata | input | 16 | Configuration write data |
| word_mode | input | 1 | Allow two-byte memory writes |
| ser_push | input | 1 | Received byte valid |
| ser_byte | input | 8 | Received byte |
| mem_ack | input | 1 | Memory accepted the current request |
| mem_req | output | 1 | Memory write requested |
| mem_wide | output | 1 | Current request is a word |
| mem_addr | output | 24 | Memory address |
| mem_data | output | 16 | Memory write data |
| fifo_level | output | 3 | Bytes queued |
| fifo_full | output | 1 | Queue holds four bytes |
| fifo_empty | output | 1 | Queue holds nothing |
| xfer_done | output | 1 | Remaining length is zero |
| tmo_irq | output | 1 | Sticky idle-timeout interrupt |

## Verification
The bench covers two same-cycle collisions. In the first, a byte arrives from the serial side in the same cycle that memory accepts a queued byte. This is provoked by holding `ser_push` and `mem_ack` together and is judged by a constant `fifo_level` and the next byte presented. In the second, a byte arrival falls exactly on a prescaler tick. The second byte is timed to land on that edge, and the interrupt must then rise a full R*PRESCALE edges later rather than one tick earlier. The pointer fold-back is swept across several limits in both byte and word modes against an arithmetic model.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
    localparam int SEG_W  = 8;
    localparam int PTR_W  = 16;
    localparam int PAGE_W = 8;
    localparam int CNT_W  = 16;
    localparam int TMO_W  = 8;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        SEL_SEG    = 3'd0,
        SEL_START  = 3'd1,
        SEL_LIMIT  = 3'd2,
        SEL_PTR    = 3'd3,
        SEL_LEN    = 3'd4,
        SEL_RELOAD = 3'd5,
        SEL_IRQCLR = 3'd6
    } cfg_sel_e;
endpackage

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit #(
    parameter int SEG_W  = 8,
    parameter int PTR_W  = 16,
    parameter int PAGE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_seg,
    input  logic                   ld_start,
    input  logic                   ld_limit,
    input  logic                   ld_ptr,
    input  logic [PTR_W-1:0]       wdata,
    input  logic                   adv,
    input  logic                   step2,
    output logic [SEG_W+PTR_W-1:0] addr
);
    localparam int LOW_W = PTR_W - PAGE_W;

    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [PAGE_W-1:0] start;
        logic [PTR_W-1:0]  limit;
        logic [PTR_W-1:0]  ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic [PTR_W:0] sum_w, over_w;
    logic           cross_w;
    logic [PTR_W-1:0] start_addr_w;

    always_comb begin
        start_addr_w = {st_q.start, {LOW_W{1'b0}}};
        sum_w   = {1'b0, st_q.ptr} + (step2 ? (PTR_W+1)'(2) : (PTR_W+1)'(1));
        over_w  = sum_w - {1'b0, st_q.limit};
        cross_w = (st_q.ptr < st_q.limit) && (sum_w >= {1'b0, st_q.limit});
        st_d = st_q;
        if (ld_seg)   st_d.seg   = wdata[SEG_W-1:0];
        if (ld_start) st_d.start = wdata[PAGE_W-1:0];
        if (ld_limit) st_d.limit = wdata;
        if (ld_ptr) begin
            st_d.ptr = wdata;
        end else if (adv) begin
            st_d.ptr = cross_w ? (start_addr_w + over_w[PTR_W-1:0]) : sum_w[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = {st_q.seg, st_q.ptr};

    // R1
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_seg |=> addr[SEG_W+PTR_W-1:PTR_W] == $past(addr[SEG_W+PTR_W-1:PTR_W]));

    // R3
    ring_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_ptr && !ld_start && !ld_limit &&
         st_q.ptr >= start_addr_w && st_q.ptr < st_q.limit &&
         {1'b0, st_q.limit} >= {1'b0, start_addr_w} + (PTR_W+1)'(2))
        |=> (st_q.ptr >= start_addr_w && st_q.ptr < st_q.limit));
endmodule

// File: rtl/dma_len_ctr.sv
module dma_len_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] wdata,
    input  logic             dec,
    input  logic             dec2,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } len_st_t;

    len_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.cnt = wdata;
        end else if (dec && st_q.cnt != '0) begin
            if (dec2 && st_q.cnt >= CNT_W'(2)) st_d.cnt = st_q.cnt - CNT_W'(2);
            else                               st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign done  = (st_q.cnt == '0);

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !ld |=> done);

    // R5
    len_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !ld && !done |=> count < $past(count));
endmodule

// File: rtl/dma_stage_fifo.sv
module dma_stage_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              din,
    input  logic [1:0]                 npop,
    output logic [DW-1:0]              head0,
    output logic [DW-1:0]              head1,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rd;
        logic [AW-1:0]            wr;
        logic [LW-1:0]            lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     acc_w;

    always_comb begin
        acc_w = push && (st_q.lvl < LW'(DEPTH));
        st_d = st_q;
        if (acc_w) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr = st_q.wr + AW'(1);
        end
        st_d.rd  = st_q.rd + AW'(npop);
        st_d.lvl = st_q.lvl + LW'(acc_w) - LW'(npop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head0 = st_q.mem[st_q.rd];
    assign head1 = st_q.mem[st_q.rd + AW'(1)];
    assign level = st_q.lvl;
    assign full  = (st_q.lvl == LW'(DEPTH));
    assign empty = (st_q.lvl == '0);

    // R6
    pop_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        LW'(npop) <= level);

    // R6
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R7
    swap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !full && npop == 2'd1 |=> $stable(level));
endmodule

// File: rtl/dma_idle_timer.sv
module dma_idle_timer #(
    parameter int TW       = 8,
    parameter int PRESCALE = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload_we,
    input  logic [TW-1:0] reload_val,
    input  logic          byte_in,
    input  logic          nonempty,
    input  logic          clr,
    output logic          irq
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [TW-1:0] reload;
        logic [TW-1:0] timer;
        logic          irq;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    tick_w, fire_w;

    always_comb begin
        tick_w = (st_q.pre == PW'(PRESCALE-1));
        fire_w = !byte_in && tick_w && (st_q.timer == TW'(1)) && nonempty;
        st_d = st_q;
        if (reload_we) st_d.reload = reload_val;
        if (byte_in) begin
            st_d.timer = st_q.reload;
            st_d.pre   = '0;
        end else begin
            st_d.pre = tick_w ? '0 : st_q.pre + PW'(1);
            if (tick_w && st_q.timer != '0) st_d.timer = st_q.timer - TW'(1);
        end
        if (clr)    st_d.irq = 1'b0;
        if (fire_w) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr |=> irq);

    // R8
    byte_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && byte_in |=> !irq);
endmodule

// File: rtl/dma_circ_chan.sv
module dma_circ_chan
    import dma_eng_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int PRESCALE   = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [2:0]                      cfg_sel,
    input  logic [15:0]                     cfg_wdata,
    input  logic                            word_mode,
    input  logic                            ser_push,
    input  logic [7:0]                      ser_byte,
    input  logic                            mem_ack,
    output logic                            mem_req,
    output logic                            mem_wide,
    output logic [23:0]                     mem_addr,
    output logic [15:0]                     mem_data,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    output logic                            fifo_full,
    output logic                            fifo_empty,
    output logic                            xfer_done,
    output logic                            tmo_irq
);
    localparam int LW = $clog2(FIFO_DEPTH+1);

    logic [CNT_W-1:0]  len_w;
    logic [BYTE_W-1:0] head0_w, head1_w;
    logic              xfer_w;
    logic [1:0]        npop_w;

    logic ld_seg_w, ld_start_w, ld_limit_w, ld_ptr_w, ld_len_w, ld_rel_w, clr_w;

    always_comb begin
        ld_seg_w   = cfg_we && (cfg_sel == SEL_SEG);
        ld_start_w = cfg_we && (cfg_sel == SEL_START);
        ld_limit_w = cfg_we && (cfg_sel == SEL_LIMIT);
        ld_ptr_w   = cfg_we && (cfg_sel == SEL_PTR);
        ld_len_w   = cfg_we && (cfg_sel == SEL_LEN);
        ld_rel_w   = cfg_we && (cfg_sel == SEL_RELOAD);
        clr_w      = cfg_we && (cfg_sel == SEL_IRQCLR);
        mem_req  = !xfer_done && !fifo_empty;
        mem_wide = word_mode && (fifo_level >= LW'(2)) && (len_w >= CNT_W'(2));
        xfer_w   = mem_req && mem_ack;
        npop_w   = xfer_w ? (mem_wide ? 2'd2 : 2'd1) : 2'd0;
        mem_data = mem_wide ? {head1_w, head0_w} : {8'h00, head0_w};
    end

    dma_ptr_unit #(.SEG_W(SEG_W), .PTR_W(PTR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .ld_seg(ld_seg_w), .ld_start(ld_start_w), .ld_limit(ld_limit_w), .ld_ptr(ld_ptr_w),
        .wdata(cfg_wdata), .adv(xfer_w), .step2(mem_wide), .addr(mem_addr)
    );

    dma_len_ctr #(.CNT_W(CNT_W)) u_len (
        .clk(clk), .rst_n(rst_n), .ld(ld_len_w), .wdata(cfg_wdata),
        .dec(xfer_w), .dec2(mem_wide), .count(len_w), .done(xfer_done)
    );

    dma_stage_fifo #(.DEPTH(FIFO_DEPTH), .DW(BYTE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(ser_push), .din(ser_byte), .npop(npop_w),
        .head0(head0_w), .head1(head1_w), .level(fifo_level),
        .full(fifo_full), .empty(fifo_empty)
    );

    dma_idle_timer #(.TW(TMO_W), .PRESCALE(PRESCALE)) u_tmr (
        .clk(clk), .rst_n(rst_n), .reload_we(ld_rel_w), .reload_val(cfg_wdata[TMO_W-1:0]),
        .byte_in(ser_push), .nonempty(!fifo_empty), .clr(clr_w), .irq(tmo_irq)
    );

    // R5
    done_no_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && !cfg_we |=> fifo_level >= $past(fifo_level));

    // R5
    done_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && !cfg_we |=> $stable(mem_addr));
endmodule

// File: tb/dma_circ_chan_tb.sv
module dma_circ_chan_tb;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        word_mode = 1'b0;
    logic        ser_push = 1'b0;
    logic [7:0]  ser_byte = '0;
    logic        mem_ack = 1'b0;
    logic        mem_req, mem_wide, fifo_full, fifo_empty, xfer_done, tmo_irq;
    logic [23:0] mem_addr;
    logic [15:0] mem_data;
    logic [2:0]  fifo_level;

    int errs = 0;
    int total = 0;

    always #5 clk = ~clk;

    dma_circ_chan #(.FIFO_DEPTH(4), .PRESCALE(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .word_mode(word_mode), .ser_push(ser_push), .ser_byte(ser_byte), .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_data(mem_data),
        .fifo_level(fifo_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .xfer_done(xfer_done), .tmo_irq(tmo_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [15:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        edge1();
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        ser_push = 1'b1; ser_byte = b;
        edge1();
        ser_push = 1'b0;
    endtask

    task automatic ack();
        mem_ack = 1'b1;
        edge1();
        mem_ack = 1'b0;
    endtask

    task automatic drain();
        cfg(3'd4, 16'h0040);
        while (!fifo_empty) ack();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

    initial begin
        logic [15:0] p, s, lim;
        logic [7:0]  v;
        #1;
        edge1(); edge1();
        rst_n = 1'b1;
        edge1();
        // R10 reset state
        check("R10 empty", {31'd0, fifo_empty}, 32'd1);
        check("R10 level", {29'd0, fifo_level}, 32'd0);
        check("R10 done", {31'd0, xfer_done}, 32'd1);
        check("R10 req", {31'd0, mem_req}, 32'd0);
        check("R10 irq", {31'd0, tmo_irq}, 32'd0);
        check("R10 addr", {8'd0, mem_addr}, 32'd0);

        // R1 R2 R3 R4 fold-back sweep, byte and word modes
        v = 8'h10;
        for (int wm = 0; wm < 2; wm++) begin
            for (int boff = 2; boff <= 5; boff++) begin
                word_mode = wm[0];
                lim = 16'h3000 + 16'(boff);
                cfg(3'd0, 16'h005A + 16'(boff));
                cfg(3'd1, 16'h0030);
                cfg(3'd2, lim);
                cfg(3'd3, 16'h3000);
                cfg(3'd4, 16'h0100);
                p = 16'h3000;
                for (int st = 0; st < 7; st++) begin
                    push(v);
                    if (wm == 1) push(v + 8'd1);
                    check("R1 addr", {8'd0, mem_addr}, {8'd0, 8'h5A + 8'(boff), p});
                    check("R4 wide", {31'd0, mem_wide}, 32'(wm));
                    if (wm == 1) check("R4 word data", {16'd0, mem_data}, {16'd0, v + 8'd1, v});
                    else         check("R4 byte data", {16'd0, mem_data}, {24'd0, v});
                    ack();
                    s = p + 16'(wm + 1);
                    if (p < lim && s >= lim) s = 16'h3000 + (s - lim);
                    p = s;
                    v = v + 8'd2;
                end
                check("R3 R2 final ptr", {16'd0, mem_addr[15:0]}, {16'd0, p});
            end
        end

        // R5 length counting and stop
        word_mode = 1'b1;
        cfg(3'd2, 16'h3010);
        cfg(3'd3, 16'h3000);
        cfg(3'd4, 16'd3);
        push(8'hA1); push(8'hA2);
        check("R4 wide with len 3", {31'd0, mem_wide}, 32'd1);
        ack();
        push(8'hA3); push(8'hA4);
        check("R4 narrow when len 1", {31'd0, mem_wide}, 32'd0);
        check("R4 narrow data", {16'd0, mem_data}, 32'h0000_00A3);
        ack();
        check("R5 done at zero", {31'd0, xfer_done}, 32'd1);
        check("R5 req low when done", {31'd0, mem_req}, 32'd0);
        check("R5 addr after", {8'd0, mem_addr}, {8'd0, 8'h5F, 16'h3003});
        ack();
        check("R5 ack ignored level", {29'd0, fifo_level}, 32'd1);
        check("R5 ack ignored addr", {8'd0, mem_addr}, {8'd0, 8'h5F, 16'h3003});
        word_mode = 1'b0;
        drain();

        // R6 capacity, order, discard
        cfg(3'd4, 16'h0000);
        for (int i = 0; i < 5; i++) push(8'hC0 + 8'(i));
        check("R6 full", {31'd0, fifo_full}, 32'd1);
        check("R6 level 4", {29'd0, fifo_level}, 32'd4);
        cfg(3'd4, 16'h0040);
        for (int i = 0; i < 4; i++) begin
            check("R6 order", {16'd0, mem_data}, {24'd0, 8'hC0 + 8'(i)});
            ack();
        end
        check("R6 fifth discarded", {31'd0, fifo_empty}, 32'd1);

        // R7 same-cycle push and pop
        push(8'hB0);
        ser_push = 1'b1; ser_byte = 8'hB1; mem_ack = 1'b1;
        edge1();
        ser_push = 1'b0; mem_ack = 1'b0;
        check("R7 level kept", {29'd0, fifo_level}, 32'd1);
        check("R7 order kept", {16'd0, mem_data}, 32'h0000_00B1);
        drain();

        // R8 idle timeout timing
        cfg(3'd4, 16'h0000);
        cfg(3'd5, 16'd3);
        push(8'h77);
        for (int k = 1; k <= 3 * P; k++) begin
            edge1();
            if (k == 3 * P - 1) check("R8 not yet", {31'd0, tmo_irq}, 32'd0);
            if (k == 3 * P)     check("R8 fires", {31'd0, tmo_irq}, 32'd1);
        end
        repeat (5) edge1();
        check("R9 sticky", {31'd0, tmo_irq}, 32'd1);
        cfg(3'd6, 16'd0);
        check("R9 cleared", {31'd0, tmo_irq}, 32'd0);
        repeat (20) edge1();
        check("R9 no refire", {31'd0, tmo_irq}, 32'd0);

        // R9 byte on a tick edge reloads
        push(8'h78);
        repeat (P - 1) edge1();
        push(8'h79);
        for (int k = 1; k <= 3 * P; k++) begin
            edge1();
            if (k == 3 * P - 1) check("R9 reload on tick", {31'd0, tmo_irq}, 32'd0);
            if (k == 3 * P)     check("R8 fires after reload", {31'd0, tmo_irq}, 32'd1);
        end
        cfg(3'd6, 16'd0);
        drain();

        // R9 empty queue at expiry
        push(8'h55);
        ack();
        repeat (3 * P + 4) edge1();
        check("R9 empty no irq", {31'd0, tmo_irq}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end
endmodule